// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

The unit checks each bus access against a small set of programmable address regions. It returns the attributes that apply to the access and a verdict on whether it may proceed. Instruction fetches are checked only against a bank of instruction regions. Data reads and writes are checked only against a separate bank of data regions. An access that matches no enabled region in its bank takes its attributes from one global default entry.

Each region is a power-of-two window, aligned to its own size, with a base page, a size code, an enable bit and six attribute bits. The six bits are supervisor read, supervisor write, user read, user write, execute, and a bit that allows speculative access. A speculative access that would be refused is held back quietly. The same access, when it is later issued non-speculatively, raises the violation flag together with the faulting address. Regions and the default entry are loaded through a single-word write port.

The address compare is combinational. The verdict is registered, so every result appears one clock after the request.

Top module: `region_mpu`

## Requirements
- R1: After reset, valid_o, hit_o, grant_o and viol_o are 0, every region is disabled, and the default entry grants all six attribute bits (attr_o reads 6'h3F for an unmatched access).
- R2: A request sampled on a rising edge (req_i=1) produces valid_o=1 for exactly the following cycle, carrying that request's results. A cycle without a request leaves valid_o, grant_o and viol_o at 0.
- R3: A region with size code c covers 4 KB << c bytes. Base address bits below that size are ignored, so the window is aligned to its size.
- R4: A data region's size code saturates at 12 (16 MB). An instruction region with a code of 20 or above covers the whole 4 GB space.
- R5: Fetches (type_i=0) match only the instruction bank. Reads (type_i=1) and writes (type_i=2) match only the data bank.
- R6: When several regions of a bank match, the lowest-numbered one supplies hit_idx_o and attr_o.
- R7: An access that matches no enabled region gives hit_o=0 and attr_o equal to the default entry.
- R8: Permission rules: a fetch needs execute; a read needs supervisor read (priv_i=1) or user read (priv_i=0); a write needs the matching write bit. A refused non-speculative access gives grant_o=0 and viol_o=1 for that result cycle only, with viol_addr_o holding the access address.
- R9: A speculative access (spec_i=1) to a region whose speculative bit is 0, or one that fails R8's rules, gives grant_o=0 and viol_o=0.
- R10: Configuration write format: cfg_wdata_i[31:12] is the base page, [11:7] the size code, [6] enable, and [5:0] the attributes {spec_ok, exec, user_wr, user_rd, sup_wr, sup_rd}. cfg_sel_i values 0..3 address data regions, 4..7 address instruction regions 0..3, and 8 addresses the default entry, which stores only [5:0]. A disabled region matches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 4 | Region or default entry selected for the write |
| cfg_wdata_i | input | 32 | Configuration word |
| req_i | input | 1 | Access request |
| addr_i | input | 32 | Access address |
| type_i | input | 2 | 0 fetch, 1 read, 2 write |
| priv_i | input | 1 | 1 supervisor, 0 user |
| spec_i | input | 1 | Access is speculative |
| valid_o | output | 1 | Result valid, one cycle after req_i |
| hit_o | output | 1 | An enabled region matched |
| hit_idx_o | output | 2 | Index of the winning region within its bank |
| attr_o | output | 6 | Applied attributes |
| grant_o | output | 1 | Access may proceed |
| viol_o | output | 1 | Protection violation |
| viol_addr_o | output | 32 | Address of the faulting access |

## Verification
Every result output is due exactly one rising edge after the request is sampled. The bench drives a request on a falling edge, lets one rising edge pass, and reads all outputs on the next falling edge. It then drops the request and, one cycle later, confirms that valid_o and viol_o have returned to 0. Configuration writes take effect on the edge that samples them, so an access driven in the following cycle already sees the new region.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int ADDR_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
  localparam int CODE_W     = 5;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_READ  = 2'd1;
  localparam logic [1:0] ACC_WRITE = 2'd2;

  typedef struct packed {
    logic spec_ok;
    logic exec;
    logic u_wr;
    logic u_rd;
    logic s_wr;
    logic s_rd;
  } perm_t;

  typedef struct packed {
    logic [PAGE_W-1:0] base;
    logic [CODE_W-1:0] code;
    logic              en;
    perm_t             perm;
  } region_t;
endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
#(
  parameter int MAX_CODE = 12
) (
  input  region_t           region_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              match_o
);
  logic [CODE_W-1:0] code_eff;
  logic [PAGE_W-1:0] mask;

  always_comb begin
    code_eff = (region_i.code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : region_i.code;
    mask     = {PAGE_W{1'b1}} << code_eff;  // shift of PAGE_W clears the mask
    match_o  = region_i.en && (((page_i ^ region_i.base) & mask) == '0);
  end
endmodule

// File: rtl/mpu_bank.sv
module mpu_bank
  import mpu_pkg::*;
#(
  parameter int N        = 4,
  parameter int MAX_CODE = 12,
  parameter int IDX_W    = 2,
  parameter int SEL_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  widx_i,
  input  region_t           wdata_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output perm_t             perm_o
);
  region_t          regs_q [N];
  logic [N-1:0]     match_w;

  for (genvar g = 0; g < N; g++) begin : g_region
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (we_i && widx_i == SEL_W'(g))         regs_q[g] <= wdata_i;
    end

    mpu_region_match #(.MAX_CODE(MAX_CODE)) u_match (
      .region_i (regs_q[g]),
      .page_i   (page_i),
      .match_o  (match_w[g])
    );
  end

  // lowest index wins
  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    perm_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_w[i]) begin
        hit_o  = 1'b1;
        idx_o  = IDX_W'(i);
        perm_o = regs_q[i].perm;
      end
    end
  end

  assert_winner_matches_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> match_w[idx_o]);
  assert_lowest_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_w & ~({N{1'b1}} << idx_o)) == '0));
  assert_no_match_no_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_w == '0) |-> !hit_o);
endmodule

// File: rtl/region_mpu.sv
module region_mpu
  import mpu_pkg::*;
#(
  parameter int N_DATA        = 4,
  parameter int N_INST        = 4,
  parameter int DATA_MAX_CODE = 12,
  parameter int INST_MAX_CODE = 20,
  localparam int N_MAX = (N_DATA > N_INST) ? N_DATA : N_INST,
  localparam int IDX_W = (N_MAX > 1) ? $clog2(N_MAX) : 1,
  localparam int SEL_W = $clog2(N_DATA + N_INST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        type_i,
  input  logic              priv_i,
  input  logic              spec_i,
  output logic              valid_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [5:0]        attr_o,
  output logic              grant_o,
  output logic              viol_o,
  output logic [ADDR_W-1:0] viol_addr_o
);
  localparam logic [SEL_W-1:0] SEL_INST = SEL_W'(N_DATA);
  localparam logic [SEL_W-1:0] SEL_GLOB = SEL_W'(N_DATA + N_INST);

  region_t          cfg_r;
  perm_t            glob_q;
  logic             d_we, i_we;
  logic [SEL_W-1:0] i_widx;
  logic             d_hit, i_hit;
  logic [IDX_W-1:0] d_idx, i_idx;
  perm_t            d_perm, i_perm;
  logic             is_fetch;

  assign cfg_r  = region_t'(cfg_wdata_i);
  assign d_we   = cfg_we_i && (cfg_sel_i < SEL_INST);
  assign i_we   = cfg_we_i && (cfg_sel_i >= SEL_INST) && (cfg_sel_i < SEL_GLOB);
  assign i_widx = cfg_sel_i - SEL_INST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                glob_q <= '1;
    else if (cfg_we_i && cfg_sel_i == SEL_GLOB) glob_q <= cfg_r.perm;
  end

  mpu_bank #(.N(N_DATA), .MAX_CODE(DATA_MAX_CODE), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_dbank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (d_we),
    .widx_i  (cfg_sel_i),
    .wdata_i (cfg_r),
    .page_i  (addr_i[ADDR_W-1:PAGE_SHIFT]),
    .hit_o   (d_hit),
    .idx_o   (d_idx),
    .perm_o  (d_perm)
  );

  mpu_bank #(.N(N_INST), .MAX_CODE(INST_MAX_CODE), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_ibank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (i_we),
    .widx_i  (i_widx),
    .wdata_i (cfg_r),
    .page_i  (addr_i[ADDR_W-1:PAGE_SHIFT]),
    .hit_o   (i_hit),
    .idx_o   (i_idx),
    .perm_o  (i_perm)
  );

  // combinational verdict
  logic             sel_hit;
  logic [IDX_W-1:0] sel_idx;
  perm_t            eff;
  logic             allowed, spec_blk, grant_c, viol_c;

  assign is_fetch = (type_i == ACC_FETCH);

  always_comb begin
    sel_hit = is_fetch ? i_hit : d_hit;
    sel_idx = is_fetch ? i_idx : d_idx;
    eff     = sel_hit ? (is_fetch ? i_perm : d_perm) : glob_q;
    unique case (type_i)
      ACC_FETCH: allowed = eff.exec;
      ACC_WRITE: allowed = priv_i ? eff.s_wr : eff.u_wr;
      default:   allowed = priv_i ? eff.s_rd : eff.u_rd;
    endcase
    spec_blk = spec_i && !eff.spec_ok;
    grant_c  = allowed && !spec_blk;
    viol_c   = !spec_i && !allowed;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      hit_o       <= 1'b0;
      hit_idx_o   <= '0;
      attr_o      <= '0;
      grant_o     <= 1'b0;
      viol_o      <= 1'b0;
      viol_addr_o <= '0;
    end else begin
      valid_o <= req_i;
      grant_o <= req_i && grant_c;
      viol_o  <= req_i && viol_c;
      if (req_i) begin
        hit_o     <= sel_hit;
        hit_idx_o <= sel_idx;
        attr_o    <= eff;
        if (viol_c) viol_addr_o <= addr_i;
      end
    end
  end

  assert_valid_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !viol_o && !grant_o));
  assert_viol_excludes_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (valid_o && !grant_o));
  assert_viol_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && viol_c) |=> (viol_o && viol_addr_o == $past(addr_i)));
  assert_spec_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && spec_i) |=> !viol_o);
  assert_fetch_bank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_fetch) |=> (hit_o == $past(i_hit)));
  assert_data_bank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !is_fetch) |=> (hit_o == $past(d_hit)));
endmodule

// File: tb/tb_region_mpu.sv
module tb_region_mpu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        req_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  type_i = '0;
  logic        priv_i = 1'b0;
  logic        spec_i = 1'b0;
  logic        valid_o, hit_o, grant_o, viol_o;
  logic [1:0]  hit_idx_o;
  logic [5:0]  attr_o;
  logic [31:0] viol_addr_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_mpu dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .req_i(req_i), .addr_i(addr_i), .type_i(type_i),
    .priv_i(priv_i), .spec_i(spec_i), .valid_o(valid_o), .hit_o(hit_o),
    .hit_idx_o(hit_idx_o), .attr_o(attr_o), .grant_o(grant_o), .viol_o(viol_o),
    .viol_addr_o(viol_addr_o)
  );

  localparam logic [1:0] F = 2'd0, RD = 2'd1, WR = 2'd2;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rword(input logic [19:0] base, input logic [4:0] code,
                                        input logic en, input logic [5:0] perm);
    return {base, code, en, perm};
  endfunction

  task automatic cfg(input logic [3:0] sel, input logic [31:0] w);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = w;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // drive at negedge, result read on the next negedge (one posedge later)
  task automatic access(input logic [31:0] a, input logic [1:0] t, input logic p, input logic s);
    req_i = 1'b1; addr_i = a; type_i = t; priv_i = p; spec_i = s;
    @(negedge clk);
    req_i = 1'b0; spec_i = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic hit, input logic [1:0] idx,
                            input logic [5:0] attr, input logic grant, input logic viol);
    chk(req, "valid", 32'(valid_o), 32'd1);
    chk(req, "hit", 32'(hit_o), 32'(hit));
    if (hit) chk(req, "idx", 32'(hit_idx_o), 32'(idx));
    chk(req, "attr", 32'(attr_o), 32'(attr));
    chk(req, "grant", 32'(grant_o), 32'(grant));
    chk(req, "viol", 32'(viol_o), 32'(viol));
  endtask

  task automatic t_reset();
    chk("R1", "valid", 32'(valid_o), 32'd0);
    chk("R1", "hit", 32'(hit_o), 32'd0);
    chk("R1", "viol", 32'(viol_o), 32'd0);
    chk("R1", "grant", 32'(grant_o), 32'd0);
    access(32'h0000_1000, RD, 1'b0, 1'b0);
    expect_res("R1", 1'b0, 2'd0, 6'h3F, 1'b1, 1'b0);
  endtask

  task automatic t_data_regions();
    cfg(4'd0, rword(20'h00010, 5'd4, 1'b1, 6'b000111));
    cfg(4'd1, rword(20'h00000, 5'd8, 1'b1, 6'h3F));
    cfg(4'd2, rword(20'h00203, 5'd4, 1'b1, 6'h3F));
    cfg(4'd3, rword(20'h00000, 5'd20, 1'b1, 6'h3F));
    // user write to user read-only region
    access(32'h0001_8000, WR, 1'b0, 1'b0);
    expect_res("R8", 1'b1, 2'd0, 6'b000111, 1'b0, 1'b1);
    chk("R8", "viol_addr", viol_addr_o, 32'h0001_8000);
    @(negedge clk);
    chk("R2", "valid idle", 32'(valid_o), 32'd0);
    chk("R8", "viol one cycle", 32'(viol_o), 32'd0);
    access(32'h0001_8000, RD, 1'b0, 1'b0);
    expect_res("R8", 1'b1, 2'd0, 6'b000111, 1'b1, 1'b0);
    access(32'h0001_8000, WR, 1'b1, 1'b0);
    expect_res("R8", 1'b1, 2'd0, 6'b000111, 1'b1, 1'b0);
    access(32'h0005_0000, WR, 1'b0, 1'b0);
    expect_res("R6", 1'b1, 2'd1, 6'h3F, 1'b1, 1'b0);
    access(32'h0020_F010, RD, 1'b0, 1'b0);
    expect_res("R3", 1'b1, 2'd2, 6'h3F, 1'b1, 1'b0);
    access(32'h0021_0000, RD, 1'b0, 1'b0);
    expect_res("R3", 1'b1, 2'd3, 6'h3F, 1'b1, 1'b0);
    access(32'h00F0_0000, RD, 1'b0, 1'b0);
    expect_res("R4", 1'b1, 2'd3, 6'h3F, 1'b1, 1'b0);
    access(32'h0200_0000, RD, 1'b0, 1'b0);
    expect_res("R4", 1'b0, 2'd0, 6'h3F, 1'b1, 1'b0);
  endtask

  task automatic t_inst_bank();
    access(32'h0001_8000, F, 1'b1, 1'b0);
    expect_res("R5", 1'b0, 2'd0, 6'h3F, 1'b1, 1'b0);
    cfg(4'd4, rword(20'h00010, 5'd4, 1'b1, 6'b000101));
    cfg(4'd5, rword(20'h00000, 5'd20, 1'b1, 6'h3F));
    access(32'h0001_8004, F, 1'b1, 1'b0);
    expect_res("R8", 1'b1, 2'd0, 6'b000101, 1'b0, 1'b1);
    chk("R8", "viol_addr", viol_addr_o, 32'h0001_8004);
    access(32'h4000_0000, F, 1'b0, 1'b0);
    expect_res("R4", 1'b1, 2'd1, 6'h3F, 1'b1, 1'b0);
    access(32'h4000_0000, RD, 1'b0, 1'b0);
    expect_res("R5", 1'b0, 2'd0, 6'h3F, 1'b1, 1'b0);
  endtask

  task automatic t_speculative();
    access(32'h0001_8000, RD, 1'b0, 1'b1);
    expect_res("R9", 1'b1, 2'd0, 6'b000111, 1'b0, 1'b0);
    access(32'h0001_8000, WR, 1'b0, 1'b1);
    expect_res("R9", 1'b1, 2'd0, 6'b000111, 1'b0, 1'b0);
    access(32'h0001_8000, WR, 1'b0, 1'b0);
    expect_res("R9", 1'b1, 2'd0, 6'b000111, 1'b0, 1'b1);
    access(32'h0005_0000, RD, 1'b0, 1'b1);
    expect_res("R9", 1'b1, 2'd1, 6'h3F, 1'b1, 1'b0);
  endtask

  task automatic t_disable_and_default();
    cfg(4'd0, rword(20'h00010, 5'd4, 1'b0, 6'b000111));
    access(32'h0001_8000, WR, 1'b0, 1'b0);
    expect_res("R10", 1'b1, 2'd1, 6'h3F, 1'b1, 1'b0);
    cfg(4'd8, rword(20'hFFFFF, 5'd31, 1'b1, 6'b010111));
    access(32'h0300_0000, WR, 1'b0, 1'b0);
    expect_res("R7", 1'b0, 2'd0, 6'b010111, 1'b0, 1'b1);
    access(32'h0300_0000, RD, 1'b0, 1'b1);
    expect_res("R7", 1'b0, 2'd0, 6'b010111, 1'b0, 1'b0);
    access(32'h0005_0000, RD, 1'b0, 1'b0);
    expect_res("R10", 1'b1, 2'd1, 6'h3F, 1'b1, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_regions();
    t_inst_bank();
    t_speculative();
    t_disable_and_default();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule